// File: doc/BRIEF.md
# Strobe-Latched Parallel Input Port

The block provides two 8-bit parallel input ports, A and B. Each has its own strobe input. A CPU reads each port through a small register-mapped bus. A mode bit per port decides what that read returns. In transparent mode it is the level on the pins at the moment of the read. In latched mode it is the snapshot taken at the last active strobe edge. Pin activity after the snapshot does not reach the CPU until the next active edge. A second register picks the active edge of each strobe, rising or falling. Every active edge also raises a per-port interrupt flag.

A typical latched use is as a data-valid qualifier: the producer presents a byte, pulses the strobe, and may then move on. Another use bridges a 16-bit data bus onto an 8-bit reader. The AND of the active-low I/O-read and memory-read lines drives strobe A, and strobe A is set to rising. The upper byte is then frozen in port A as the read cycle ends, and the CPU fetches it with a later access.

The mode register is a full byte. Only its two low bits affect this block. The rest are kept for neighbouring timer and shift logic, and they read back as written.

Top module: `strobe_latch_port`

## Requirements
- R1: After reset, the mode register, the edge-select register, both snapshot registers, both interrupt flags and `rdata` are zero, so both ports start transparent.
- R2: The mode register sits at offset 2. Bit 0 makes port A latched and bit 1 makes port B latched (1 = latched, 0 = transparent). All 8 bits read back as written. Bits 7..2 change no port behaviour.
- R3: A read with `cs` and `rd` high at a clock edge loads `rdata` at that edge, and `rdata` holds until the next read. Port B is at offset 0 and port A is at offset 1. A transparent port returns the pin levels present at that edge.
- R4: A latched port returns the pins captured at its most recent active strobe edge. Pin changes after that capture do not alter the value returned.
- R5: The edge-select register sits at offset 3. Bit 0 covers strobe A and bit 1 covers strobe B (0 = falling edge active, 1 = rising edge active). A strobe transition of the other direction neither captures nor sets a flag.
- R6: Each strobe passes through a two-flop synchronizer. Pins that are held steady from the strobe transition through the third following clock edge are the ones captured.
- R7: Each active edge sets that port's flag. The flags read at offset 4, with bit 0 for A and bit 1 for B. `irq` is the OR of both flags. A read of a port's input register clears its flag, and so does writing 1 to its flag bit. A new active edge in the same cycle as a clear leaves the flag set.
- R8: A port read in the same cycle as a capture returns the previously captured value. The new value is returned from the next read on.
- R9: With strobe A wired to the AND of the two active-low read lines and set to rising, port A in latched mode holds the byte present as the read cycle ends.
- R10: Offsets 5 to 7 read as zero. Writes to offsets 0 and 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_pins | input | 8 | Port A pin levels |
| pb_pins | input | 8 | Port B pin levels |
| stb_a | input | 1 | Port A strobe |
| stb_b | input | 1 | Port B strobe |
| irq | output | 1 | OR of the two interrupt flags |

## Verification
A corrupted snapshot register shows up on the very next latched read of that port, one cycle after the read is issued, as a byte that differs from the pins present at the last active edge. A wrong edge-select or synchronizer state shows up as `irq` rising at the wrong time or not at all. The error becomes visible within three clocks of the strobe change. A flag that fails to clear, or a set that loses to a clear, is visible at once on `irq` and on the next read of offset 4. Random stimulus mixes latched and transparent reads with pin changes between capture and read, so a snapshot that follows the pins is caught quickly.

// File: rtl/slp_pkg.sv
package slp_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NPORTS  = 2;
    localparam int PORT_A  = 0;
    localparam int PORT_B  = 1;

    typedef enum logic [ADDR_W-1:0] {
        OFS_PORTB = 3'd0,
        OFS_PORTA = 3'd1,
        OFS_MODE  = 3'd2,
        OFS_EDGE  = 3'd3,
        OFS_FLAG  = 3'd4
    } reg_ofs_e;

    typedef struct packed {
        logic              cs;
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic hits(bus_req_t b, reg_ofs_e ofs);
        return b.cs && (b.addr == ofs);
    endfunction

    function automatic logic [ADDR_W-1:0] port_ofs(int idx);
        return (idx == PORT_A) ? OFS_PORTA : OFS_PORTB;
    endfunction
endpackage

// File: rtl/slp_strobe_edge.sv
module slp_strobe_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic rising_i,
    output logic active_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= strobe_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    always_comb begin
        if (rising_i) active_o = sync_q[STAGES-1] & ~prev_q;
        else          active_o = ~sync_q[STAGES-1] & prev_q;
    end

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        active_o |=> !active_o);
endmodule

// File: rtl/slp_capture.sv
module slp_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         edge_i,
    input  logic [W-1:0] pins_i,
    input  logic         latch_en_i,
    input  logic         read_i,
    input  logic         clr_i,
    output logic [W-1:0] value_o,
    output logic         flag_o
);
    logic [W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst)         snap_q <= '0;
        else if (edge_i) snap_q <= pins_i;
    end

    always_ff @(posedge clk) begin
        if (rst)                  flag_o <= 1'b0;
        else if (edge_i)          flag_o <= 1'b1;
        else if (read_i || clr_i) flag_o <= 1'b0;
    end

    assign value_o = latch_en_i ? snap_q : pins_i;

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_i |=> $stable(snap_q));
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        edge_i |=> flag_o);
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ((read_i || clr_i) && !edge_i) |=> !flag_o);
endmodule

// File: rtl/slp_ctrl_regs.sv
module slp_ctrl_regs
    import slp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    output logic [DATA_W-1:0] mode_o,
    output logic [NPORTS-1:0] rising_o,
    output logic [NPORTS-1:0] port_rd_o,
    output logic [NPORTS-1:0] flag_w1c_o
);
    logic wr_mode, wr_edge, wr_flag;

    assign wr_mode = req_i.wr && hits(req_i, OFS_MODE);
    assign wr_edge = req_i.wr && hits(req_i, OFS_EDGE);
    assign wr_flag = req_i.wr && hits(req_i, OFS_FLAG);

    always_ff @(posedge clk) begin
        if (rst)          mode_o <= '0;
        else if (wr_mode) mode_o <= req_i.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)          rising_o <= '0;
        else if (wr_edge) rising_o <= req_i.wdata[NPORTS-1:0];
    end

    genvar p;
    generate
        for (p = 0; p < NPORTS; p++) begin : g_dec
            assign port_rd_o[p]  = req_i.rd && req_i.cs && (req_i.addr == port_ofs(p));
            assign flag_w1c_o[p] = wr_flag && req_i.wdata[p];
        end
    endgenerate

    // R1
    mode_reset_chk: assert property (@(posedge clk)
        rst |=> (mode_o == '0 && rising_o == '0));
endmodule

// File: rtl/strobe_latch_port.sv
module strobe_latch_port
    import slp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_pins,
    input  logic [DATA_W-1:0] pb_pins,
    input  logic              stb_a,
    input  logic              stb_b,
    output logic              irq
);
    bus_req_t          req;
    logic [DATA_W-1:0] mode;
    logic [NPORTS-1:0] rising, port_rd, w1c, active, flags;
    logic [DATA_W-1:0] pins   [NPORTS];
    logic [DATA_W-1:0] value  [NPORTS];
    logic              strobe [NPORTS];
    logic [DATA_W-1:0] rd_mux;

    assign req     = '{cs: cs, rd: rd, wr: wr, addr: addr, wdata: wdata};
    assign pins[PORT_A]   = pa_pins;
    assign pins[PORT_B]   = pb_pins;
    assign strobe[PORT_A] = stb_a;
    assign strobe[PORT_B] = stb_b;

    slp_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .mode_o     (mode),
        .rising_o   (rising),
        .port_rd_o  (port_rd),
        .flag_w1c_o (w1c)
    );

    genvar p;
    generate
        for (p = 0; p < NPORTS; p++) begin : g_port
            slp_strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk      (clk),
                .rst      (rst),
                .strobe_i (strobe[p]),
                .rising_i (rising[p]),
                .active_o (active[p])
            );
            slp_capture #(.W(DATA_W)) u_cap (
                .clk        (clk),
                .rst        (rst),
                .edge_i     (active[p]),
                .pins_i     (pins[p]),
                .latch_en_i (mode[p]),
                .read_i     (port_rd[p]),
                .clr_i      (w1c[p]),
                .value_o    (value[p]),
                .flag_o     (flags[p])
            );
        end
    endgenerate

    always_comb begin
        case (addr)
            OFS_PORTB: rd_mux = value[PORT_B];
            OFS_PORTA: rd_mux = value[PORT_A];
            OFS_MODE:  rd_mux = mode;
            OFS_EDGE:  rd_mux = DATA_W'(rising);
            OFS_FLAG:  rd_mux = DATA_W'(flags);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           rdata <= '0;
        else if (cs && rd) rdata <= rd_mux;
    end

    assign irq = |flags;

    // R3
    transparent_a_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && addr == OFS_PORTA && !mode[PORT_A]) |=> (rdata == $past(pa_pins)));
    // R10
    hole_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && addr > OFS_FLAG) |=> (rdata == '0));
    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|active));
endmodule

// File: tb/strobe_latch_port_tb.sv
module strobe_latch_port_tb_top;
    logic       clk = 0, rst = 1, cs = 0, rd = 0, wr = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rdata, pa = 0, pb = 0;
    logic       sa = 0, sb = 0, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] m_cap [2];
    logic [1:0] m_flag = 0, m_rise = 0;
    logic [7:0] m_mode = 0;

    always #2.5 clk = ~clk;

    strobe_latch_port dut_i (.clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pa_pins(pa), .pb_pins(pb),
        .stb_a(sa), .stb_b(sb), .irq(irq));

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic bus_rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1; rd = 1; addr = a;
        @(negedge clk); cs = 0; rd = 0; d = rdata;
    endtask

    function automatic logic [7:0] exp_port(int p);
        logic [7:0] live;
        live = (p == 0) ? pa : pb;
        return m_mode[p] ? m_cap[p] : live;
    endfunction

    task automatic read_port(int p, string req);
        logic [7:0] e, d;
        @(negedge clk);
        e = exp_port(p);
        cs = 1; rd = 1; addr = (p == 0) ? 3'd1 : 3'd0;
        @(negedge clk); cs = 0; rd = 0; d = rdata;
        m_flag[p] = 1'b0;
        check(req, d, e);
    endtask

    task automatic strobe_evt(int p, logic [7:0] val);
        logic lvl;
        @(negedge clk);
        if (p == 0) begin pa = val; sa = ~sa; lvl = sa; end
        else        begin pb = val; sb = ~sb; lvl = sb; end
        repeat (4) @(negedge clk);
        if (lvl == m_rise[p]) begin m_cap[p] = val; m_flag[p] = 1'b1; end
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        m_cap[0] = 0; m_cap[1] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        check("R1 rdata", rdata, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        bus_rd(3'd2, d); check("R1 mode", d, 8'h00);
        bus_rd(3'd4, d); check("R1 flags", d, 8'h00);
        pa = 8'h5A; pb = 8'hC3;
        read_port(0, "R1/R3 transparent A");
        read_port(1, "R3 transparent B");

        // R2 readback, upper bits inert
        bus_wr(3'd2, 8'hFC); m_mode = 8'hFC;
        bus_rd(3'd2, d); check("R2 readback", d, 8'hFC);
        pa = 8'h11; read_port(0, "R2 upper bits inert");
        bus_wr(3'd2, 8'h03); m_mode = 8'h03;

        // R5 falling default: rising strobe ignored
        strobe_evt(0, 8'hAA);
        check("R5 ignored edge irq", {7'b0, irq}, 8'h00);
        read_port(0, "R5 ignored edge");
        strobe_evt(0, 8'h3C);
        check("R7 irq set", {7'b0, irq}, 8'h01);
        bus_rd(3'd4, d); check("R7 flag A", d, 8'h01);
        pa = 8'hFF;
        read_port(0, "R4 later pins ignored");
        check("R7 read clears", {7'b0, irq}, 8'h00);

        // R7 W1C
        bus_wr(3'd3, 8'h02); m_rise = 2'b10;
        strobe_evt(1, 8'h77);
        bus_rd(3'd4, d); check("R7 flag B", d, 8'h02);
        bus_wr(3'd4, 8'h02); m_flag[1] = 0;
        bus_rd(3'd4, d); check("R7 w1c", d, 8'h00);
        pb = 8'h00; read_port(1, "R4/R6 port B capture");
        bus_rd(3'd3, d); check("R5 edge reg", d, 8'h02);

        // R10
        bus_wr(3'd0, 8'hEE); bus_wr(3'd1, 8'hEE);
        read_port(1, "R10 write ignored B");
        read_port(0, "R10 write ignored A");
        bus_rd(3'd6, d); check("R10 hole", d, 8'h00);

        // R8 read same cycle as capture (A falling; sa currently 0)
        @(negedge clk); pa = 8'h99; sa = 1; // rising: ignored
        repeat (4) @(negedge clk);
        @(negedge clk); sa = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); cs = 1; rd = 1; addr = 3'd1;
        @(negedge clk); cs = 0; rd = 0;
        check("R8 old value", rdata, m_cap[0]);
        m_cap[0] = 8'h99;
        check("R8 flag set wins", {7'b0, irq}, 8'h01);
        read_port(0, "R8 new value next read");

        // R9 16-bit bridging: stb_a = io_rd_n & mem_rd_n, rising edge
        bus_wr(3'd3, 8'h03); m_rise = 2'b11;
        @(negedge clk); sa = 0; pa = 8'h12;
        repeat (3) @(negedge clk);
        pa = 8'hB7; repeat (2) @(negedge clk);
        sa = 1;
        repeat (4) @(negedge clk);
        pa = 8'h00;
        m_cap[0] = 8'hB7; m_flag[0] = 1;
        read_port(0, "R9 upper byte held");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op; int p;
            op = $urandom_range(0, 4); p = $urandom_range(0, 1);
            case (op)
                0, 1: strobe_evt(p, 8'($urandom));
                2: begin
                    @(negedge clk);
                    if (p == 0) pa = 8'($urandom); else pb = 8'($urandom);
                    read_port(p, p ? "R4 random B" : "R4 random A");
                end
                3: begin
                    logic [7:0] nm;
                    nm = 8'($urandom);
                    bus_wr(3'd2, nm); m_mode = nm;
                end
                default: begin
                    bus_rd(3'd4, d);
                    check("R7 random flags", d, {6'b0, m_flag});
                end
            endcase
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule